// File: doc/BRIEF.md
# Compare and Increment/Decrement Flag Unit

This block is an 8-bit arithmetic slice for a small processor datapath. It handles three operations: compare, increment and decrement. Compare subtracts the second operand from the first and only changes the status flags; nothing is written back. Increment and decrement write a result, and they change only the zero, negative, overflow and sign flags. The carry and half-carry bits stay as they were, so a carry produced by an earlier compare survives a counter update.

The result and its write enable come straight from the operand and operation inputs within the same cycle. The six status flags sit in a register that loads on the clock edge of each accepted operation and holds its value otherwise. The equal and not-equal branches read the registered zero flag.

Top module: `cfu_flag_unit`

## Requirements
- R1: While reset is asserted and after its release, `flags` reads 0 until the first accepted operation.
- R2: Compare (`op_sel` = 0) drives `result` = opd − opr modulo 256 and holds `res_we` low. On the next edge it loads C, Z, N, V, S and H.
- R3: For every accepted compare, increment or decrement, Z (`flags[1]`) after the edge is 1 exactly when the 8-bit result was 0x00.
- R4: Increment (`op_sel` = 1) gives opd + 1 and decrement (`op_sel` = 2) gives opd − 1, both with `res_we` high. Neither one changes C (`flags[0]`) or H (`flags[5]`).
- R5: N (`flags[2]`) takes bit 7 of the result. S (`flags[4]`) always equals N xor V.
- R6: When `op_vld` is low, or `op_sel` = 3, `res_we` stays low and all flags keep their values.
- R7: Incrementing 0xFF gives 0x00 and sets Z. Decrementing 0x00 gives 0xFF and sets N.
- R8: V (`flags[3]`) is the signed overflow of the compare subtraction. For increment it is set only when opd = 0x7F. For decrement it is set only when opd = 0x80.
- R9: For a compare, C is set when opr > opd taken as unsigned values. H is set when the low nibble of opr is greater than the low nibble of opd, which is a borrow out of bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operation accepted this cycle |
| op_sel | input | 2 | 0 compare, 1 increment, 2 decrement, 3 no effect |
| opd | input | 8 | First operand (destination) |
| opr | input | 8 | Second operand (compare only) |
| result | output | 8 | Computed value |
| res_we | output | 1 | Result write enable |
| flags | output | 6 | Registered flags: [0] C, [1] Z, [2] N, [3] V, [4] S, [5] H |

## Verification
In one cycle this block can both rewrite some flag bits and keep others, and a fault can easily mix the two. The case is provoked by a compare that leaves C and H set, followed directly by an increment of 0xFF: the increment must set Z while C and H stay at their old values. The scoreboard judges the full flag word after the edge against a model that updates only the bits each operation defines. A swept sequence of mixed operations, including idle cycles and the no-effect code, repeats this check across many flag histories.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    typedef enum logic [1:0] {
        OP_CMP = 2'd0,
        OP_INC = 2'd1,
        OP_DEC = 2'd2,
        OP_RSV = 2'd3
    } cfu_op_e;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } cfu_flags_t;
endpackage

// File: rtl/cfu_sub.sv
module cfu_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff,
    output logic         borrow,
    output logic         half_borrow,
    output logic         ovf
);
    localparam int NIB = W / 2;

    logic [W:0]   full;
    logic [NIB:0] low;

    always_comb begin
        full        = {1'b0, a} - {1'b0, b};
        low         = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
        diff        = full[W-1:0];
        borrow      = full[W];
        half_borrow = low[NIB];
        ovf         = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/cfu_step.sv
module cfu_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         down,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (down) begin
            res = a - 1'b1;
            ovf = (a == MIN_NEG);
        end else begin
            res = a + 1'b1;
            ovf = (a == MAX_POS);
        end
    end
endmodule

// File: rtl/cfu_flag_unit.sv
module cfu_flag_unit
    import cfu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_vld,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opd,
    input  logic [W-1:0] opr,
    output logic [W-1:0] result,
    output logic         res_we,
    output logic [5:0]   flags
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         we;
        cfu_flags_t   fl;
    } cfu_next_t;

    cfu_flags_t flags_q;
    cfu_next_t  nxt_d;

    logic [W-1:0] sub_diff;
    logic         sub_c, sub_h, sub_v;
    logic [W-1:0] step_res;
    logic         step_v;

    cfu_sub #(.W(W)) sub_i (
        .a(opd), .b(opr), .diff(sub_diff),
        .borrow(sub_c), .half_borrow(sub_h), .ovf(sub_v)
    );

    cfu_step #(.W(W)) step_i (
        .a(opd), .down(op_sel == OP_DEC), .res(step_res), .ovf(step_v)
    );

    always_comb begin
        nxt_d.res = '0;
        nxt_d.we  = 1'b0;
        nxt_d.fl  = flags_q;
        if (op_vld) begin
            unique case (cfu_op_e'(op_sel))
                OP_CMP: begin
                    nxt_d.res  = sub_diff;
                    nxt_d.fl.c = sub_c;
                    nxt_d.fl.h = sub_h;
                    nxt_d.fl.v = sub_v;
                    nxt_d.fl.z = (sub_diff == '0);
                    nxt_d.fl.n = sub_diff[W-1];
                    nxt_d.fl.s = sub_diff[W-1] ^ sub_v;
                end
                OP_INC, OP_DEC: begin
                    nxt_d.res  = step_res;
                    nxt_d.we   = 1'b1;
                    nxt_d.fl.v = step_v;
                    nxt_d.fl.z = (step_res == '0);
                    nxt_d.fl.n = step_res[W-1];
                    nxt_d.fl.s = step_res[W-1] ^ step_v;
                end
                default: begin
                    nxt_d.res = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= nxt_d.fl;
    end

    assign result = nxt_d.res;
    assign res_we = nxt_d.we;
    assign flags  = flags_q;

    // R4: carry and half-carry survive increment and decrement
    p_keep_ch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && (op_sel == OP_INC || op_sel == OP_DEC))
        |=> (flags_q.c == $past(flags_q.c)) && (flags_q.h == $past(flags_q.h)));

    // R6: idle or no-effect code holds every flag
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_vld || op_sel == OP_RSV) |=> $stable(flags_q));

    // R3: registered Z follows the result of the accepted operation
    p_z_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel != OP_RSV) |=> (flags_q.z == ($past(result) == '0)));

    // R5: sign flag consistent with N and V
    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.s == (flags_q.n ^ flags_q.v));

    // R2: compare never writes back
    p_cmp_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel == OP_CMP) |-> !res_we);

    // R7: increment of all-ones wraps to zero
    p_inc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel == OP_INC && opd == '1) |-> (result == '0));
endmodule

// File: tb/cfu_flag_unit_tb_top.sv
module cfu_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_vld = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [7:0] opd = 8'd0;
    logic [7:0] opr = 8'd0;
    logic [7:0] result;
    logic       res_we;
    logic [5:0] flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit        chk_res;
        logic [7:0] res;
        logic      we;
        logic [5:0] fl;
        string     tag;
    } exp_t;

    exp_t sb[$];
    logic [5:0] mf = 6'd0; // model flags: [0]C [1]Z [2]N [3]V [4]S [5]H

    always #10 clk = ~clk;

    cfu_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_sel(op_sel),
        .opd(opd), .opr(opr), .result(result), .res_we(res_we), .flags(flags)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // driver: applies one operation at a falling edge and queues expectations
    task automatic drive(bit vld, int op, int d, int r, string tag);
        exp_t e;
        int res;
        bit nb, vb;
        @(negedge clk);
        op_vld = vld; op_sel = op[1:0]; opd = d[7:0]; opr = r[7:0];
        e.chk_res = 1'b0; e.res = 8'd0; e.we = 1'b0; e.tag = tag;
        if (vld && op == 0) begin
            res = (d - r) & 255;
            vb  = (((d ^ r) & 128) != 0) && (((res ^ d) & 128) != 0);
            nb  = (res & 128) != 0;
            mf[0] = (d < r);
            mf[5] = ((d & 15) < (r & 15));
            mf[1] = (res == 0); mf[2] = nb; mf[3] = vb; mf[4] = nb ^ vb;
            e.chk_res = 1'b1; e.res = res[7:0];
        end else if (vld && (op == 1 || op == 2)) begin
            res = (op == 1) ? ((d + 1) & 255) : ((d + 255) & 255);
            vb  = (op == 1) ? (d == 127) : (d == 128);
            nb  = (res & 128) != 0;
            mf[1] = (res == 0); mf[2] = nb; mf[3] = vb; mf[4] = nb ^ vb;
            e.chk_res = 1'b1; e.res = res[7:0]; e.we = 1'b1;
        end
        e.fl = mf;
        sb.push_back(e);
    endtask

    // monitor: after each rising edge, compare outputs with the oldest item
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "res_we", int'(res_we), int'(e.we));
                if (e.chk_res) check(e.tag, "result", int'(result), int'(e.res));
                check(e.tag, "flags", int'(flags), int'(e.fl));
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "flags in reset", int'(flags), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", int'(flags), 0);

        drive(1, 0, 8'h05, 8'h05, "R3 cmp equal");
        drive(1, 0, 8'h03, 8'h05, "R9 cmp borrow");          // C=1 H=1 N=1
        drive(1, 1, 8'hFF, 8'h00, "R7 inc wrap keeps C/H R4");
        drive(1, 1, 8'h7F, 8'h00, "R8 inc overflow");
        drive(1, 2, 8'h00, 8'h00, "R7 dec wrap");
        drive(1, 2, 8'h80, 8'h00, "R8 dec overflow");
        drive(1, 0, 8'h80, 8'h01, "R8 cmp overflow R5");
        drive(1, 0, 8'h10, 8'h01, "R9 cmp half borrow");
        drive(0, 1, 8'hFF, 8'h00, "R6 idle");
        drive(1, 3, 8'h00, 8'h55, "R6 no-effect code");
        drive(1, 0, 8'h7F, 8'hFF, "R2 cmp signed ovf");
        drive(1, 2, 8'h01, 8'h00, "R3 dec to zero");
        for (int i = 0; i < 48; i++) begin
            drive(i % 5 != 4, i % 4, (i * 37 + 11) & 255, (i * 53 + 3) & 255,
                  "R2 R4 R5 sweep");
        end
        drive(0, 0, 8'h00, 8'h00, "R6 idle tail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule